// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block writes and reads configuration registers inside a front-end chip over a three-wire serial link, plus a separate reset line for the chip's loading logic. A command carries a register address, an operation code, a value and a length select. The block shifts out one frame per command. The frame holds a constant chip identifier, then the address, the operation, one spacer bit, and the value field of 8, 10 or 34 bits. Every field goes out most significant bit first.

On a read, the block adds as many extra clock periods as the value is long. On each rising edge of those periods it samples the chip's serial-out line. At the end it returns the assembled word together with a one-cycle done pulse.

The same data and clock pins also drive the chip's output multiplexer. A control line tells the chip which function is active. While the block is idle and multiplexer mode is requested, it drops that control line and passes the multiplexer clock and data straight through.

Top module: `sprog_master`

## Requirements
- R1: While `rst` is high and for `RST_CYC` clock cycles after it falls, `prog_rst` is high, `prog_ctrl` is high, `prog_clk` is low and `cmd_ready` is low. After that `prog_rst` stays low.
- R2: A frame sends these fields in this order, each MSB first: the identifier 01010, the 5-bit `cmd_addr`, the 3-bit `cmd_op`, one spacer bit of 0, and the low L bits of `cmd_value`. The frame is 14+L bits long. Operation codes are read 001, write 010, set 011, reset 100 and default 101.
- R3: `cmd_len` selects L. Code 00 gives 8, code 01 gives 10, and codes 10 and 11 give 34.
- R4: Each serial bit occupies `HALF` cycles with `prog_clk` low, then `HALF` cycles with it high. `prog_din` changes only as `prog_clk` falls, so it is stable at every rising edge.
- R5: For operation 001 the frame is followed by L more clock periods with `prog_din` at 0. `prog_dout` is sampled at each of their rising edges, and the first bit sampled becomes the MSB of the L-bit result.
- R6: `done` is high for exactly one cycle after the last falling edge of `prog_clk`. At the same time `rd_value` holds the read result, right-justified with zeros above it, or 0 for any operation other than read.
- R7: `cmd_ready` is high only when the block is idle, out of reset and multiplexer mode is not requested. A `cmd_valid` while `cmd_ready` is low starts no frame and gives no `done`.
- R8: When the block is idle and `mux_sel` is high, `prog_ctrl` is 0, and `prog_clk` and `prog_din` follow `mux_clk` and `mux_din` one cycle later.
- R9: If `mux_sel` rises during a frame, the frame still completes unchanged. The link is yielded to the multiplexer only afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_addr | input | 5 | Register address |
| cmd_op | input | 3 | Operation code |
| cmd_len | input | 2 | Value length select |
| cmd_value | input | 34 | Value to send (low L bits used) |
| mux_sel | input | 1 | Request output multiplexer mode |
| mux_clk | input | 1 | Multiplexer clock to pass through |
| mux_din | input | 1 | Multiplexer reset or data to pass through |
| prog_clk | output | 1 | Serial clock to the chip |
| prog_din | output | 1 | Serial data to the chip |
| prog_ctrl | output | 1 | 1 selects programming, 0 selects multiplexer |
| prog_rst | output | 1 | Reset of the chip's loading logic |
| prog_dout | input | 1 | Serial readback from the chip |
| done | output | 1 | One-cycle end-of-command pulse |
| rd_value | output | 34 | Readback value |

## Verification
A bit counter that is off by one shows at the ports as a frame with the wrong number of rising edges. It also shifts every field that follows, so the captured frame differs within that same command. A wrong shift or alignment of the value corrupts the bits after the spacer, or the readback word, and this is visible when `done` rises. A state machine that fails to return to idle holds `cmd_ready` low or keeps the multiplexer from taking the pins, and this shows within a few cycles of the next request.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  localparam int ID_W    = 5;
  localparam logic [ID_W-1:0] CHIP_ID = 5'b01010;
  localparam int ADDR_W  = 5;
  localparam int OP_W    = 3;
  localparam int HDR_W   = ID_W + ADDR_W + OP_W + 1;
  localparam int LEN_S   = 8;
  localparam int LEN_M   = 10;
  localparam int VAL_W   = 34;
  localparam int FRAME_W = HDR_W + VAL_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [OP_W-1:0] {
    OP_READ  = 3'b001,
    OP_WRITE = 3'b010,
    OP_SET   = 3'b011,
    OP_CLEAR = 3'b100,
    OP_DEFLT = 3'b101
  } op_t;

  typedef enum logic [2:0] {
    ST_RST, ST_IDLE, ST_SHIFT, ST_RDBK, ST_DONE
  } st_t;
endpackage

// File: rtl/sprog_frame.sv
module sprog_frame
  import sprog_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic [OP_W-1:0]    op,
  input  logic [1:0]         len_sel,
  input  logic [VAL_W-1:0]   value,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   frame_bits,
  output logic [CNT_W-1:0]   val_len,
  output logic               is_read
);
  logic [CNT_W-1:0] sh_amt;
  logic [VAL_W-1:0] val_aln;

  always_comb begin
    case (len_sel)
      2'b00:   val_len = CNT_W'(LEN_S);
      2'b01:   val_len = CNT_W'(LEN_M);
      default: val_len = CNT_W'(VAL_W);
    endcase
    sh_amt     = CNT_W'(VAL_W) - val_len;
    val_aln    = value << sh_amt;
    frame      = {CHIP_ID, addr, op, 1'b0, val_aln};
    frame_bits = CNT_W'(HDR_W) + val_len;
    is_read    = (op == OP_READ);
  end
endmodule

// File: rtl/sprog_tick.sv
module sprog_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [TW-1:0] cnt;

  assign tick = en && (cnt == TW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sprog_engine.sv
module sprog_engine
  import sprog_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  output logic               tick_en,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   frame_bits,
  input  logic [CNT_W-1:0]   val_len,
  input  logic               is_read,
  input  logic               mux_sel,
  input  logic               mux_clk,
  input  logic               mux_din,
  output logic               prog_clk,
  output logic               prog_din,
  output logic               prog_ctrl,
  output logic               prog_rst,
  input  logic               prog_dout,
  output logic               done,
  output logic [VAL_W-1:0]   rd_value
);
  localparam int RW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

  st_t              state;
  logic [RW-1:0]    rcnt;
  logic [FRAME_W-1:0] sh;
  logic [VAL_W-1:0] rd_sh;
  logic [CNT_W-1:0] bits;
  logic [CNT_W-1:0] vlen;
  logic             hi;
  logic             rd_flag;

  assign tick_en   = (state == ST_SHIFT) || (state == ST_RDBK);
  assign cmd_ready = (state == ST_IDLE) && !mux_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RST;
      rcnt      <= '0;
      prog_rst  <= 1'b1;
      prog_ctrl <= 1'b1;
      prog_clk  <= 1'b0;
      prog_din  <= 1'b0;
      done      <= 1'b0;
      rd_value  <= '0;
      sh        <= '0;
      rd_sh     <= '0;
      bits      <= '0;
      vlen      <= '0;
      hi        <= 1'b0;
      rd_flag   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_RST: begin
          if (rcnt == RW'(RST_CYC - 1)) begin
            state    <= ST_IDLE;
            prog_rst <= 1'b0;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (mux_sel) begin
            prog_ctrl <= 1'b0;
            prog_clk  <= mux_clk;
            prog_din  <= mux_din;
          end else begin
            prog_ctrl <= 1'b1;
            prog_clk  <= 1'b0;
            if (cmd_valid) begin
              sh       <= frame_in;
              prog_din <= frame_in[FRAME_W-1];
              bits     <= frame_bits;
              vlen     <= val_len;
              rd_flag  <= is_read;
              rd_sh    <= '0;
              hi       <= 1'b0;
              state    <= ST_SHIFT;
            end else begin
              prog_din <= 1'b0;
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!hi) begin
              prog_clk <= 1'b1;
              hi       <= 1'b1;
            end else begin
              prog_clk <= 1'b0;
              hi       <= 1'b0;
              if (bits == CNT_W'(1)) begin
                prog_din <= 1'b0;
                if (rd_flag) begin
                  state <= ST_RDBK;
                  bits  <= vlen;
                end else begin
                  state <= ST_DONE;
                end
              end else begin
                bits     <= bits - 1'b1;
                sh       <= {sh[FRAME_W-2:0], 1'b0};
                prog_din <= sh[FRAME_W-2];
              end
            end
          end
        end
        ST_RDBK: begin
          if (tick) begin
            if (!hi) begin
              prog_clk <= 1'b1;
              hi       <= 1'b1;
              rd_sh    <= {rd_sh[VAL_W-2:0], prog_dout};
            end else begin
              prog_clk <= 1'b0;
              hi       <= 1'b0;
              if (bits == CNT_W'(1)) state <= ST_DONE;
              else                   bits  <= bits - 1'b1;
            end
          end
        end
        ST_DONE: begin
          done     <= 1'b1;
          rd_value <= rd_sh;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RDY_OUT_OF_RST: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !prog_rst); // R1
  AST_DIN_HELD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    (prog_ctrl && $past(prog_ctrl) && $rose(prog_clk)) |-> $stable(prog_din)); // R4
  AST_CLK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !tick) |=> $stable(prog_clk)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_RD_ZERO_NONREAD: assert property (@(posedge clk) disable iff (rst)
    (done && !rd_flag) |-> (rd_value == '0)); // R6
  AST_CTRL_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    ($past(tick_en) && tick_en) |-> prog_ctrl); // R9
endmodule

// File: rtl/sprog_master.sv
module sprog_master
  import sprog_pkg::*;
#(
  parameter int HALF    = 2,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [1:0]        cmd_len,
  input  logic [VAL_W-1:0]  cmd_value,
  input  logic              mux_sel,
  input  logic              mux_clk,
  input  logic              mux_din,
  output logic              prog_clk,
  output logic              prog_din,
  output logic              prog_ctrl,
  output logic              prog_rst,
  input  logic              prog_dout,
  output logic              done,
  output logic [VAL_W-1:0]  rd_value
);
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   frame_bits;
  logic [CNT_W-1:0]   val_len;
  logic               is_read;
  logic               tick;
  logic               tick_en;

  sprog_frame u_frame (
    .addr       (cmd_addr),
    .op         (cmd_op),
    .len_sel    (cmd_len),
    .value      (cmd_value),
    .frame      (frame),
    .frame_bits (frame_bits),
    .val_len    (val_len),
    .is_read    (is_read)
  );

  sprog_tick #(.HALF(HALF)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (tick_en),
    .tick (tick)
  );

  sprog_engine #(.RST_CYC(RST_CYC)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .tick_en    (tick_en),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .frame_in   (frame),
    .frame_bits (frame_bits),
    .val_len    (val_len),
    .is_read    (is_read),
    .mux_sel    (mux_sel),
    .mux_clk    (mux_clk),
    .mux_din    (mux_din),
    .prog_clk   (prog_clk),
    .prog_din   (prog_din),
    .prog_ctrl  (prog_ctrl),
    .prog_rst   (prog_rst),
    .prog_dout  (prog_dout),
    .done       (done),
    .rd_value   (rd_value)
  );
endmodule

// File: tb/sprog_master_tb.sv
module sprog_master_tb_top;
  localparam int HALF = 2;
  localparam int RST_CYC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [4:0] cmd_addr = '0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_len = '0;
  logic [33:0] cmd_value = '0;
  logic mux_sel = 1'b0, mux_clk = 1'b0, mux_din = 1'b0;
  logic prog_clk, prog_din, prog_ctrl, prog_rst;
  logic prog_dout = 1'b0;
  logic done;
  logic [33:0] rd_value;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;

  logic [81:0] cap;
  int ncap;
  int nrise;
  int fb;
  int rlen;
  int rb_idx;
  logic [33:0] rb_val;

  always #4 clk = ~clk;

  sprog_master #(.HALF(HALF), .RST_CYC(RST_CYC)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_value(cmd_value),
    .mux_sel(mux_sel), .mux_clk(mux_clk), .mux_din(mux_din),
    .prog_clk(prog_clk), .prog_din(prog_din), .prog_ctrl(prog_ctrl),
    .prog_rst(prog_rst), .prog_dout(prog_dout), .done(done), .rd_value(rd_value)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (done) done_cnt = done_cnt + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected finish earlier", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // chip-side model: capture on rising edge, drive readback on falling edge
  always @(posedge prog_clk) begin
    if (prog_ctrl) begin
      cap = {cap[80:0], prog_din};
      ncap = ncap + 1;
      nrise = nrise + 1;
    end
  end
  always @(negedge prog_clk) begin
    if (prog_ctrl && nrise >= fb && rb_idx < rlen) begin
      prog_dout = rb_val[rlen-1-rb_idx];
      rb_idx = rb_idx + 1;
    end
  end

  task automatic chk(string req, logic [81:0] act, logic [81:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int len_of(logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 10 : 34;
  endfunction

  function automatic logic [81:0] exp_frame(logic [4:0] a, logic [2:0] o, int l,
                                            logic [33:0] v, bit rd);
    logic [81:0] e;
    e = {68'd0, 5'b01010, a, o, 1'b0};
    for (int i = l - 1; i >= 0; i--) e = {e[80:0], v[i]};
    if (rd) for (int i = 0; i < l; i++) e = {e[80:0], 1'b0};
    return e;
  endfunction

  function automatic logic [33:0] mask(logic [33:0] v, int l);
    return (l >= 34) ? v : (v & ((34'd1 << l) - 34'd1));
  endfunction

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic run_cmd(logic [4:0] a, logic [2:0] o, logic [1:0] ls,
                         logic [33:0] v, logic [33:0] rbv, bit mux_mid);
    int l;
    bit ok, rd;
    l = len_of(ls);
    rd = (o == 3'b001);
    for (int k = 0; k < 1000 && !cmd_ready; k++) @(negedge clk);
    cap = '0; ncap = 0; nrise = 0; rb_idx = 0;
    fb = 14 + l; rlen = rd ? l : 0; rb_val = rbv;
    cmd_addr = a; cmd_op = o; cmd_len = ls; cmd_value = v;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (mux_mid) begin
      repeat (20) @(negedge clk);
      mux_sel = 1'b1; mux_clk = 1'b1; mux_din = 1'b1;
      // ignored command while busy (R7)
      cmd_valid = 1'b1; cmd_addr = ~a; cmd_value = ~v;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    wait_done(ok);
    chk(mux_mid ? "R9 done reached" : "R6 done reached", 82'(ok), 82'd1);
    chk(mux_mid ? "R9 frame intact" : "R2 frame bits", cap, exp_frame(a, o, l, v, rd));
    chk("R3 clock count", 82'(ncap), 82'(rd ? 14 + 2 * l : 14 + l));
    chk(rd ? "R5 readback" : "R6 rd_value zero", 82'(rd_value), 82'(rd ? mask(rbv, l) : 34'd0));
    @(negedge clk);
    chk("R6 done one cycle", 82'(done), 82'd0);
  endtask

  initial begin
    bit ok;
    int d0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 prog_rst in reset", 82'(prog_rst), 82'd1);
    chk("R1 ready low in reset", 82'(cmd_ready), 82'd0);
    chk("R1 clk low in reset", 82'(prog_clk), 82'd0);
    rst = 1'b0;
    repeat (RST_CYC - 1) @(negedge clk);
    chk("R1 prog_rst held", 82'(prog_rst), 82'd1);
    chk("R1 ready held low", 82'(cmd_ready), 82'd0);
    repeat (2) @(negedge clk);
    chk("R1 prog_rst released", 82'(prog_rst), 82'd0);
    chk("R1 ready after reset", 82'(cmd_ready), 82'd1);

    // directed corners
    run_cmd(5'h00, 3'b010, 2'b00, 34'h0, 34'h0, 0);
    run_cmd(5'h1f, 3'b001, 2'b10, 34'h3_ffff_ffff, 34'h2_aaaa_5555, 0);
    run_cmd(5'h15, 3'b001, 2'b00, 34'h0ff, 34'h0a5, 0);
    run_cmd(5'h0a, 3'b001, 2'b01, 34'h155, 34'h3c3, 0);
    run_cmd(5'h03, 3'b101, 2'b11, 34'h1_2345_6789, 34'h0, 0);
    run_cmd(5'h11, 3'b011, 2'b01, 34'h3_ffff_fc01, 34'h0, 0);

    // random commands
    for (int n = 0; n < 24; n++) begin
      logic [2:0] o;
      o = 3'(1 + ($urandom % 5));
      run_cmd(5'($urandom), o, 2'($urandom), {2'($urandom), 32'($urandom)},
              {2'($urandom), 32'($urandom)}, 0);
    end

    // multiplexer pass-through (R8)
    @(negedge clk);
    mux_sel = 1'b1; mux_clk = 1'b1; mux_din = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 ctrl low", 82'(prog_ctrl), 82'd0);
    chk("R8 clk follows", 82'(prog_clk), 82'd1);
    chk("R8 din follows", 82'(prog_din), 82'd0);
    chk("R7 ready low in mux", 82'(cmd_ready), 82'd0);
    mux_clk = 1'b0; mux_din = 1'b1;
    @(negedge clk);
    chk("R8 clk one cycle", 82'(prog_clk), 82'd0);
    chk("R8 din one cycle", 82'(prog_din), 82'd1);
    d0 = done_cnt;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (60) @(negedge clk);
    chk("R7 no done in mux", 82'(done_cnt - d0), 82'd0);
    chk("R7 ctrl still mux", 82'(prog_ctrl), 82'd0);
    mux_sel = 1'b0; mux_clk = 1'b0; mux_din = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 ctrl restored", 82'(prog_ctrl), 82'd1);

    // mux request and stray command during a frame (R9, R7)
    d0 = done_cnt;
    run_cmd(5'h0c, 3'b001, 2'b01, 34'h2b7, 34'h1e1, 1);
    repeat (2) @(negedge clk);
    chk("R9 yielded after frame", 82'(prog_ctrl), 82'd0);
    chk("R9 clk passed after frame", 82'(prog_clk), 82'd1);
    repeat (60) @(negedge clk);
    chk("R7 single done", 82'(done_cnt - d0), 82'd1);
    mux_sel = 1'b0; mux_clk = 1'b0; mux_din = 1'b0;
    repeat (3) @(negedge clk);
    run_cmd(5'h07, 3'b100, 2'b00, 34'h3_0000_005a, 34'h0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule